// File: doc/BRIEF.md
# Program-Counter Address-Match Interrupt Unit

This unit watches the program counter of a processor core and raises an interrupt request when an instruction fetch lands on one of two software-programmed 20-bit addresses. Each channel has its own match address and enable bit. Both are programmed through a small 8-bit register bus that carries a byte address, write data, and write and read strobes. A match is reported through a per-channel hit flag and a combined request line. The request does not pass through the global interrupt mask or the priority level, so debug hooks and patch points fire no matter what state the core is in.

A match is reported only in a cycle that carries the instruction-fetch strobe. Each matching fetch therefore produces exactly one pulse. When the external data bus runs in 8-bit mode, fetches from the external area are never reported. Register writes take effect at the next clock edge.

Top module: `pc_watch_irq`

## Requirements
- R1: After reset both channels are disabled and both match addresses are 0. No hit is reported, even for a fetch from address 0.
- R2: The enable register is at byte address 0x0009. Bit 0 enables channel 0 and bit 1 enables channel 1, with 1 meaning enabled. Bits 7..2 ignore writes and read as 0.
- R3: Channel 0's match address is written and read as bits 7..0 at 0x0010, bits 15..8 at 0x0011 and bits 19..16 at bits 3..0 of 0x0012. Channel 1 uses 0x0014, 0x0015 and 0x0016 in the same layout.
- R4: Bits 7..4 of each top address byte (0x0012, 0x0016) ignore writes and read as 0.
- R5: matchHit[i] is high, combinationally within the same cycle, when fetchStb is high, channel i is enabled and pcValue equals channel i's match address.
- R6: matchHit stays 0 in any cycle where fetchStb is low, whatever the PC value.
- R7: Both channels can hit in the same cycle. irqReq is high exactly when at least one bit of matchHit is high. No mask or priority input exists.
- R8: With extArea and extBus8 both high, matchHit is 0. Either flag alone does not suppress a match.
- R9: A register write takes effect at the next clock edge. A fetch in the cycle of the write compares against the previous value.
- R10: Reads of 0x0008, 0x000A, 0x0013 and 0x0017 return 0 and change no state. regRdata is 0 whenever regRe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 16 | Register bus byte address |
| regWdata | input | 8 | Register write data |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regRdata | output | 8 | Register read data (combinational) |
| pcValue | input | 20 | Program counter |
| fetchStb | input | 1 | Instruction-fetch strobe |
| extArea | input | 1 | Current fetch targets the external area |
| extBus8 | input | 1 | External data bus is configured 8 bits wide |
| matchHit | output | 2 | Per-channel match flag |
| irqReq | output | 1 | Combined match request |

## Verification
Two functions can fall in the same cycle: a register write that changes a match address or an enable, and a fetch that is compared against that register. The bench provokes this by writing a new low address byte while fetching the old address. The hit must still be reported in that cycle and must be gone on the next fetch. A second overlap comes from both channels matching one PC value. Both flags and the single request must appear together. A behavioural model that applies writes only after the edge judges both cases on every clock.

// File: rtl/pc_watch_pkg.sv
package pc_watch_pkg;
  localparam int CH_N      = 2;
  localparam int PC_W      = 20;
  localparam int BUS_AW    = 16;
  localparam int DATA_W    = 8;
  localparam int BYTES_CH  = 3;
  localparam int TOP_W     = PC_W - 2 * DATA_W;
  localparam int SLOT_N    = CH_N * BYTES_CH;
  localparam int EN_OFS    = 'h0009;
  localparam int ADDR_BASE = 'h0010;
  localparam int CH_STRIDE = 'h0004;

  typedef struct packed {
    logic              enWr;
    logic              enRd;
    logic [SLOT_N-1:0] byteWr;
    logic [SLOT_N-1:0] byteRd;
  } regStrobe_t;
endpackage

// File: rtl/pc_watch_ctrl.sv
module pc_watch_ctrl
  import pc_watch_pkg::*;
(
  input  logic [BUS_AW-1:0] regAddr,
  input  logic              regWe,
  input  logic              regRe,
  output regStrobe_t        strobe
);
  logic [SLOT_N-1:0] slotSel;
  logic              enSel;

  localparam logic [BUS_AW-1:0] EN_ADDR = EN_OFS[BUS_AW-1:0];

  assign enSel = (regAddr == EN_ADDR);

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    for (genvar b = 0; b < BYTES_CH; b++) begin : g_byte
      localparam int SLOT = ADDR_BASE + CH_STRIDE * ch + b;
      assign slotSel[ch*BYTES_CH+b] = (regAddr == SLOT[BUS_AW-1:0]);
    end
  end

  always_comb begin
    strobe.enWr   = regWe && enSel;
    strobe.enRd   = regRe && enSel;
    strobe.byteWr = regWe ? slotSel : '0;
    strobe.byteRd = regRe ? slotSel : '0;
  end
endmodule

// File: rtl/pc_watch_dp.sv
module pc_watch_dp
  import pc_watch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [PC_W-1:0]   pcValue,
  input  logic              fetchStb,
  input  logic              extArea,
  input  logic              extBus8,
  output logic [DATA_W-1:0] regRdata,
  output logic [CH_N-1:0]   matchHit,
  output logic              irqReq
);
  logic [CH_N-1:0] chEn;
  logic [PC_W-1:0] matchAddr [CH_N];
  logic            suppress;

  always_ff @(posedge clk) begin
    if (!rstN)            chEn <= '0;
    else if (strobe.enWr) chEn <= regWdata[CH_N-1:0];
  end

  assign suppress = extArea && extBus8;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchAddr[ch] <= '0;
      end else begin
        if (strobe.byteWr[ch*BYTES_CH+0]) matchAddr[ch][DATA_W-1:0]        <= regWdata;
        if (strobe.byteWr[ch*BYTES_CH+1]) matchAddr[ch][2*DATA_W-1:DATA_W] <= regWdata;
        if (strobe.byteWr[ch*BYTES_CH+2]) matchAddr[ch][PC_W-1:2*DATA_W]   <= regWdata[TOP_W-1:0];
      end
    end

    assign matchHit[ch] = fetchStb && chEn[ch] && !suppress && (pcValue == matchAddr[ch]);
  end

  assign irqReq = |matchHit;

  always_comb begin
    regRdata = '0;
    if (strobe.enRd) regRdata[CH_N-1:0] = chEn;
    for (int ch = 0; ch < CH_N; ch++) begin
      if (strobe.byteRd[ch*BYTES_CH+0]) regRdata = matchAddr[ch][DATA_W-1:0];
      if (strobe.byteRd[ch*BYTES_CH+1]) regRdata = matchAddr[ch][2*DATA_W-1:DATA_W];
      if (strobe.byteRd[ch*BYTES_CH+2])
        regRdata = {{(DATA_W-TOP_W){1'b0}}, matchAddr[ch][PC_W-1:2*DATA_W]};
    end
  end
endmodule

// File: rtl/pc_watch_irq.sv
module pc_watch_irq
  import pc_watch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regWe,
  input  logic              regRe,
  output logic [DATA_W-1:0] regRdata,
  input  logic [PC_W-1:0]   pcValue,
  input  logic              fetchStb,
  input  logic              extArea,
  input  logic              extBus8,
  output logic [CH_N-1:0]   matchHit,
  output logic              irqReq
);
  regStrobe_t strobe;

  pc_watch_ctrl u_ctrl (
    .regAddr(regAddr),
    .regWe  (regWe),
    .regRe  (regRe),
    .strobe (strobe)
  );

  pc_watch_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .regWdata(regWdata),
    .pcValue (pcValue),
    .fetchStb(fetchStb),
    .extArea (extArea),
    .extBus8 (extBus8),
    .regRdata(regRdata),
    .matchHit(matchHit),
    .irqReq  (irqReq)
  );
endmodule

// File: rtl/pc_watch_chk.sv
module pc_watch_chk
  import pc_watch_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [BUS_AW-1:0] regAddr,
  input logic              regRe,
  input logic [DATA_W-1:0] regRdata,
  input logic              fetchStb,
  input logic              extArea,
  input logic              extBus8,
  input logic [CH_N-1:0]   matchHit,
  input logic              irqReq
);
  assert_no_hit_without_fetch_R6: assert property (@(posedge clk) disable iff (!rstN)
    !fetchStb |-> (matchHit == '0));

  assert_ext8_suppress_R8: assert property (@(posedge clk) disable iff (!rstN)
    (extArea && extBus8) |-> (matchHit == '0));

  assert_req_needs_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($countones(matchHit) != 0));

  assert_hit_raises_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(matchHit) != 0) |-> irqReq);

  assert_top_nibble_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && (regAddr == 16'h0012 || regAddr == 16'h0016)) |-> (regRdata[7:4] == 4'h0));

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && (regAddr == 16'h0013 || regAddr == 16'h0017)) |-> (regRdata == '0));

  assert_enable_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == 16'h0009) |-> (regRdata[7:2] == 6'h00));
endmodule

bind pc_watch_irq pc_watch_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regRe   (regRe),
  .regRdata(regRdata),
  .fetchStb(fetchStb),
  .extArea (extArea),
  .extBus8 (extBus8),
  .matchHit(matchHit),
  .irqReq  (irqReq)
);

// File: tb/sim_pc_watch_irq.sv
`timescale 1ns/1ps
module sim_pc_watch_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic        regWe = 1'b0;
  logic        regRe = 1'b0;
  logic [7:0]  regRdata;
  logic [19:0] pcValue = '0;
  logic        fetchStb = 1'b0;
  logic        extArea = 1'b0;
  logic        extBus8 = 1'b0;
  logic [1:0]  matchHit;
  logic        irqReq;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // behavioural reference state
  logic [1:0]  mEn = 2'b00;
  logic [19:0] mAddr0 = '0;
  logic [19:0] mAddr1 = '0;

  always #2 clk = ~clk;

  pc_watch_irq u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRe(regRe), .regRdata(regRdata), .pcValue(pcValue),
    .fetchStb(fetchStb), .extArea(extArea), .extBus8(extBus8),
    .matchHit(matchHit), .irqReq(irqReq)
  );

  function automatic logic [7:0] mRead(input logic [15:0] a);
    case (a)
      16'h0009: return {6'b0, mEn};
      16'h0010: return mAddr0[7:0];
      16'h0011: return mAddr0[15:8];
      16'h0012: return {4'b0, mAddr0[19:16]};
      16'h0014: return mAddr1[7:0];
      16'h0015: return mAddr1[15:8];
      16'h0016: return {4'b0, mAddr1[19:16]};
      default:  return 8'h00;
    endcase
  endfunction

  task automatic mWrite(input logic [15:0] a, input logic [7:0] d);
    case (a)
      16'h0009: mEn = d[1:0];
      16'h0010: mAddr0[7:0] = d;
      16'h0011: mAddr0[15:8] = d;
      16'h0012: mAddr0[19:16] = d[3:0];
      16'h0014: mAddr1[7:0] = d;
      16'h0015: mAddr1[15:8] = d;
      16'h0016: mAddr1[19:16] = d[3:0];
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, update model at posedge
  task automatic step(input string tag, input logic [19:0] pc, input logic fe,
                      input logic ea, input logic e8, input logic we, input logic re,
                      input logic [15:0] a, input logic [7:0] wd);
    logic [1:0] expHit;
    pcValue = pc; fetchStb = fe; extArea = ea; extBus8 = e8;
    regWe = we; regRe = re; regAddr = a; regWdata = wd;
    #1;
    expHit[0] = fe && mEn[0] && !(ea && e8) && (pc == mAddr0);
    expHit[1] = fe && mEn[1] && !(ea && e8) && (pc == mAddr1);
    chk(tag, "matchHit", int'(matchHit), int'(expHit));
    chk(tag, "irqReq", int'(irqReq), int'(expHit != 2'b00));
    chk(tag, "regRdata", int'(regRdata), re ? int'(mRead(a)) : 0);
    @(posedge clk);
    if (rstN && we) mWrite(a, wd);
    @(negedge clk);
  endtask

  task automatic wr(input string tag, input logic [15:0] a, input logic [7:0] d);
    step(tag, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
    chk(tag, "model read", int'(mRead(a)), int'(exp));
    step(tag, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, 8'h0);
  endtask

  task automatic fetch(input string tag, input logic [19:0] pc, input logic ea, input logic e8);
    step(tag, pc, 1'b1, ea, e8, 1'b0, 1'b0, 16'h0, 8'h0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    fetch("R1", 20'h00000, 1'b0, 1'b0);
    rd("R1", 16'h0009, 8'h00);
    rd("R1", 16'h0012, 8'h00);
    // R2: enable register, upper bits ignored
    wr("R2", 16'h0009, 8'hFF);
    rd("R2", 16'h0009, 8'h03);
    // R3 / R4: address bytes
    wr("R3", 16'h0010, 8'h45);
    wr("R3", 16'h0011, 8'h23);
    wr("R4", 16'h0012, 8'hF1);
    wr("R3", 16'h0014, 8'hDE);
    wr("R3", 16'h0015, 8'hBC);
    wr("R3", 16'h0016, 8'h0A);
    rd("R3", 16'h0010, 8'h45);
    rd("R3", 16'h0011, 8'h23);
    rd("R4", 16'h0012, 8'h01);
    rd("R3", 16'h0014, 8'hDE);
    rd("R3", 16'h0015, 8'hBC);
    rd("R3", 16'h0016, 8'h0A);
    // R5: matches on fetch
    fetch("R5", 20'h12345, 1'b0, 1'b0);
    fetch("R5", 20'hABCDE, 1'b0, 1'b0);
    fetch("R5", 20'h12344, 1'b0, 1'b0);
    // R6: no strobe, no hit
    step("R6", 20'h12345, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
    step("R6", 20'hABCDE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 8'h0);
    // R2: disable channel 0
    wr("R2", 16'h0009, 8'h02);
    fetch("R2", 20'h12345, 1'b0, 1'b0);
    fetch("R2", 20'hABCDE, 1'b0, 1'b0);
    // R7: both channels on one address
    wr("R7", 16'h0009, 8'h03);
    wr("R7", 16'h0010, 8'hDE);
    wr("R7", 16'h0011, 8'hBC);
    wr("R7", 16'h0012, 8'h0A);
    fetch("R7", 20'hABCDE, 1'b0, 1'b0);
    // R8: external-area suppression
    fetch("R8", 20'hABCDE, 1'b1, 1'b1);
    fetch("R8", 20'hABCDE, 1'b1, 1'b0);
    fetch("R8", 20'hABCDE, 1'b0, 1'b1);
    // R9: write and fetch in the same cycle
    step("R9", 20'hABCDE, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0014, 8'h00);
    fetch("R9", 20'hABCDE, 1'b0, 1'b0);
    fetch("R9", 20'hABC00, 1'b0, 1'b0);
    step("R9", 20'hABCDE, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0009, 8'h00);
    fetch("R9", 20'hABCDE, 1'b0, 1'b0);
    // R10: unmapped reads, no side effects
    wr("R10", 16'h0009, 8'h03);
    rd("R10", 16'h0008, 8'h00);
    rd("R10", 16'h000A, 8'h00);
    rd("R10", 16'h0013, 8'h00);
    rd("R10", 16'h0017, 8'h00);
    wr("R10", 16'h0013, 8'hFF);
    wr("R10", 16'h0017, 8'hFF);
    rd("R10", 16'h0009, 8'h03);
    rd("R10", 16'h0012, 8'h0A);
    fetch("R10", 20'hABCDE, 1'b0, 1'b0);
    // R1: reset again clears everything
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mEn = 2'b00; mAddr0 = '0; mAddr1 = '0;
    rd("R1", 16'h0009, 8'h00);
    rd("R1", 16'h0014, 8'h00);
    fetch("R1", 20'h00000, 1'b0, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule